// File: doc/BRIEF.md
# Single-Sector Task-File Transfer Sequencer

This block sits on the host side of an I/O-mapped ATA task file and carries out one complete single-sector transfer on its own. Once it gets a start pulse with a cylinder, head, sector number, drive bit and direction, it does the following in order:

- programs the task-file registers;
- issues the read or write command;
- polls the status register until the device asks for data;
- moves 256 sixteen-bit words through the data register;
- polls status once more until the device reports ready.

Words move between the data register and a local word buffer. On a read, each word the device returns is written into the buffer. On a write, each word is fetched from the buffer.

Each register access is a complete bus cycle with three parts. First comes one clock of chip select with the address driven. Then comes a read or write strobe held for a programmable number of clocks. Last comes one clock of hold with the address still driven. The sequence ends with a one-clock `done` pulse on success. It ends instead with a one-clock `error` pulse in two cases: a status read shows the error bit, or a poll runs past its programmable limit.

Top module: `ata_sector_seq`

## Requirements
- R1: After reset `iordN`, `iowrN` and `ce1N` are high, and `busy`, `done` and `error` are low.
- R2: A transfer begins with six register writes in this fixed order:
  - address 4h: cylinder low byte;
  - address 5h: cylinder high byte;
  - address 6h: drive/head byte;
  - address 3h: sector number;
  - address 2h: the value 01h;
  - address 7h: the command.
  Each value travels on `dataOut[7:0]`, with `dataOut[15:8]` zero.
- R3: The drive/head byte has bits 7 and 5 set, bit 6 clear, the drive bit in bit 4 and the head number in bits 3..0.
- R4: The command byte is 20h when `isWrite` is 0 (read) and 30h when `isWrite` is 1 (write).
- R5: After the command, the block reads address 7h again and again while the value is 80h. The data burst starts only after a read returns exactly 58h.
- R6: The burst is exactly 256 accesses to address 0h, with buffer index 0 to 255 in order.
  - On a read, each word is written to the buffer at its index through `bufWrEn`/`bufWrData`.
  - On a write, the word driven is `bufRdData` at that index.
- R7: After the burst, address 7h is polled while it reads 80h. On 50h, `done` pulses for one clock, `busy` is low in that same clock, and no further access follows.
- R8: A status read with bit 0 set, in either polling phase, ends the sequence. `error` pulses and `done` does not, and no further access follows.
- R9: If `max(pollLimit,1)` status reads in one polling phase have not produced the awaited value, the sequence ends with an `error` pulse right after the last of them.
- R10: Each strobe is low for exactly `max(strobeLen,1)` clocks. `ce1N` is low and `busAddr` is stable for one clock before the strobe falls and for one clock after it rises.
- R11: A start pulse while `busy` is high is ignored. The running sequence keeps the parameters latched at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| isWrite | input | 1 | 1 = sector write, 0 = sector read |
| cylinder | input | 16 | Cylinder number |
| head | input | 4 | Head number |
| driveSel | input | 1 | Drive select bit |
| sectorNum | input | 8 | Sector number |
| strobeLen | input | 8 | Strobe width in clocks (0 behaves as 1) |
| pollLimit | input | 16 | Maximum status reads per polling phase (0 behaves as 1) |
| busAddr | output | 3 | Task-file register address |
| ce1N | output | 1 | Active-low card select |
| iordN | output | 1 | Active-low I/O read strobe |
| iowrN | output | 1 | Active-low I/O write strobe |
| dataOut | output | 16 | Write data to the bus |
| dataOutEn | output | 1 | High while the block drives write data |
| dataIn | input | 16 | Read data from the bus |
| bufAddr | output | 8 | Word buffer index |
| bufRdData | input | 16 | Buffer word at `bufAddr` (combinational) |
| bufWrEn | output | 1 | Buffer write enable |
| bufWrData | output | 16 | Buffer write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-clock success pulse |
| error | output | 1 | One-clock failure pulse |

## Verification
The assertions assume three things about the inputs:
- `dataIn` is settled by the last clock of each read strobe;
- the buffer returns `bufRdData` for the current `bufAddr` in the same clock;
- `start` is only a request, with no timing promise needed, because every transfer parameter is latched when the sequence leaves idle.

The bench's device model keeps to these assumptions. It recomputes `dataIn` on the falling edge from the address it sees and its own status counters. It advances those counters only when a strobe ends. It serves the buffer from an array that is indexed combinationally. The stimulus changes the parameter inputs only while the block is idle, with one exception: the deliberate start-while-busy case. That case checks that the change has no effect.

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;

  typedef enum logic [1:0] {
    ACC_TASK   = 2'd0,
    ACC_STATUS = 2'd1,
    ACC_DATA   = 2'd2
  } accKind_t;

  typedef struct packed {
    logic     go;
    logic     rd;
    accKind_t kind;
    logic     loadParams;
    logic     clrStep;
    logic     incStep;
    logic     clrPoll;
    logic     incPoll;
    logic     bufWrite;
  } ctlStrobes_t;

  localparam logic [7:0] ST_BUSY  = 8'h80;
  localparam logic [7:0] ST_DRQ   = 8'h58;
  localparam logic [7:0] ST_READY = 8'h50;
  localparam logic [7:0] CMD_READ  = 8'h20;
  localparam logic [7:0] CMD_WRITE = 8'h30;
  localparam logic [7:0] ONE_SECTOR = 8'h01;

  localparam logic [2:0] RA_DATA   = 3'h0;
  localparam logic [2:0] RA_COUNT  = 3'h2;
  localparam logic [2:0] RA_SECTOR = 3'h3;
  localparam logic [2:0] RA_CYL_LO = 3'h4;
  localparam logic [2:0] RA_CYL_HI = 3'h5;
  localparam logic [2:0] RA_DRVHD  = 3'h6;
  localparam logic [2:0] RA_CMDSTS = 3'h7;

  localparam int TASK_STEPS = 6;

endpackage

// File: rtl/ata_bus_cycle.sv
module ata_bus_cycle #(
  parameter int DATA_W   = 16,
  parameter int STROBE_W = 8,
  parameter int ADDR_W   = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                go,
  input  logic                rd,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [STROBE_W-1:0] strobeLen,
  input  logic [DATA_W-1:0]   dataIn,
  output logic [ADDR_W-1:0]   busAddr,
  output logic                ce1N,
  output logic                iordN,
  output logic                iowrN,
  output logic [DATA_W-1:0]   dataOut,
  output logic                dataOutEn,
  output logic [DATA_W-1:0]   rdData,
  output logic                accDone
);

  typedef enum logic [1:0] {B_IDLE, B_SETUP, B_STROBE, B_HOLD} bState_t;

  bState_t             state;
  logic [STROBE_W-1:0] cnt;
  logic                rdQ;
  logic [ADDR_W-1:0]   addrQ;
  logic [DATA_W-1:0]   wdataQ;
  logic [DATA_W-1:0]   rdataQ;
  logic                active;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= B_IDLE;
      cnt    <= '0;
      rdQ    <= 1'b0;
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      case (state)
        B_IDLE: begin
          if (go) begin
            addrQ  <= addr;
            rdQ    <= rd;
            wdataQ <= wdata;
            state  <= B_SETUP;
          end
        end
        B_SETUP: begin
          cnt   <= (strobeLen == '0) ? '0 : strobeLen - 1'b1;
          state <= B_STROBE;
        end
        B_STROBE: begin
          if (cnt == '0) begin
            if (rdQ) rdataQ <= dataIn;
            state <= B_HOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= B_IDLE;
      endcase
    end
  end

  assign active    = (state != B_IDLE);
  assign ce1N      = !active;
  assign busAddr   = active ? addrQ : '0;
  assign iordN     = !((state == B_STROBE) && rdQ);
  assign iowrN     = !((state == B_STROBE) && !rdQ);
  assign dataOutEn = active && !rdQ;
  assign dataOut   = dataOutEn ? wdataQ : '0;
  assign rdData    = rdataQ;
  assign accDone   = (state == B_HOLD);

  AST_STROBE_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    (!iordN || !iowrN) |-> !ce1N) else $error("strobe without select"); // R10

  AST_SETUP_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(iordN) || $fell(iowrN)) |-> ($past(!ce1N) && $stable(busAddr)))
    else $error("no setup clock"); // R10

  AST_HOLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(iordN) || $rose(iowrN)) |-> (!ce1N && $stable(busAddr)))
    else $error("no hold clock"); // R10

  AST_GO_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    go |-> (state == B_IDLE)) else $error("access issued while bus cycle busy"); // R10

endmodule

// File: rtl/ata_seq_datapath.sv
module ata_seq_datapath
  import ata_seq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int STROBE_W = 8,
  parameter int POLL_W   = 16,
  parameter int WORDS    = 256,
  parameter int STEP_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         ctl,
  input  logic                isWrite,
  input  logic [15:0]         cylinder,
  input  logic [3:0]          head,
  input  logic                driveSel,
  input  logic [7:0]          sectorNum,
  input  logic [STROBE_W-1:0] strobeLen,
  input  logic [POLL_W-1:0]   pollLimit,
  input  logic [DATA_W-1:0]   dataIn,
  input  logic [DATA_W-1:0]   bufRdData,
  output logic [2:0]          busAddr,
  output logic                ce1N,
  output logic                iordN,
  output logic                iowrN,
  output logic [DATA_W-1:0]   dataOut,
  output logic                dataOutEn,
  output logic [STEP_W-1:0]   bufAddr,
  output logic                bufWrEn,
  output logic [DATA_W-1:0]   bufWrData,
  output logic                accDone,
  output logic [7:0]          statusByte,
  output logic                taskLast,
  output logic                wordLast,
  output logic                pollExpired,
  output logic                isWriteQ
);

  logic [15:0]         cylQ;
  logic [3:0]          headQ;
  logic                drvQ;
  logic [7:0]          sectQ;
  logic [STROBE_W-1:0] strobeLenQ;
  logic [POLL_W-1:0]   pollLimitQ;
  logic [STEP_W-1:0]   stepCnt;
  logic [POLL_W-1:0]   pollCnt;
  logic [2:0]          taskAddr;
  logic [7:0]          taskByte;
  logic [2:0]          accAddr;
  logic [DATA_W-1:0]   accWdata;
  logic [DATA_W-1:0]   rdData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cylQ       <= '0;
      headQ      <= '0;
      drvQ       <= 1'b0;
      sectQ      <= '0;
      isWriteQ   <= 1'b0;
      strobeLenQ <= '0;
      pollLimitQ <= '0;
    end else if (ctl.loadParams) begin
      cylQ       <= cylinder;
      headQ      <= head;
      drvQ       <= driveSel;
      sectQ      <= sectorNum;
      isWriteQ   <= isWrite;
      strobeLenQ <= strobeLen;
      pollLimitQ <= pollLimit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepCnt <= '0;
      pollCnt <= '0;
    end else begin
      if (ctl.loadParams || ctl.clrStep) stepCnt <= '0;
      else if (ctl.incStep)              stepCnt <= stepCnt + 1'b1;
      if (ctl.loadParams || ctl.clrPoll) pollCnt <= '0;
      else if (ctl.incPoll)              pollCnt <= pollCnt + 1'b1;
    end
  end

  always_comb begin
    case (stepCnt[2:0])
      3'd0:    begin taskAddr = RA_CYL_LO; taskByte = cylQ[7:0]; end
      3'd1:    begin taskAddr = RA_CYL_HI; taskByte = cylQ[15:8]; end
      3'd2:    begin taskAddr = RA_DRVHD;  taskByte = {3'b101, drvQ, headQ}; end
      3'd3:    begin taskAddr = RA_SECTOR; taskByte = sectQ; end
      3'd4:    begin taskAddr = RA_COUNT;  taskByte = ONE_SECTOR; end
      default: begin taskAddr = RA_CMDSTS; taskByte = isWriteQ ? CMD_WRITE : CMD_READ; end
    endcase
  end

  always_comb begin
    case (ctl.kind)
      ACC_TASK:   begin accAddr = taskAddr;  accWdata = {{(DATA_W-8){1'b0}}, taskByte}; end
      ACC_STATUS: begin accAddr = RA_CMDSTS; accWdata = '0; end
      default:    begin accAddr = RA_DATA;   accWdata = bufRdData; end
    endcase
  end

  ata_bus_cycle #(
    .DATA_W  (DATA_W),
    .STROBE_W(STROBE_W),
    .ADDR_W  (3)
  ) u_bus (
    .clk      (clk),
    .rstN     (rstN),
    .go       (ctl.go),
    .rd       (ctl.rd),
    .addr     (accAddr),
    .wdata    (accWdata),
    .strobeLen(strobeLenQ),
    .dataIn   (dataIn),
    .busAddr  (busAddr),
    .ce1N     (ce1N),
    .iordN    (iordN),
    .iowrN    (iowrN),
    .dataOut  (dataOut),
    .dataOutEn(dataOutEn),
    .rdData   (rdData),
    .accDone  (accDone)
  );

  assign statusByte  = rdData[7:0];
  assign taskLast    = (stepCnt == STEP_W'(TASK_STEPS - 1));
  assign wordLast    = (stepCnt == STEP_W'(WORDS - 1));
  assign pollExpired = ({1'b0, pollCnt} + {{POLL_W{1'b0}}, 1'b1}) >= {1'b0, pollLimitQ};
  assign bufAddr     = stepCnt;
  assign bufWrEn     = ctl.bufWrite;
  assign bufWrData   = rdData;

  AST_BUFWR_READ_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> (!isWriteQ && accDone && busAddr == RA_DATA))
    else $error("buffer write outside read burst"); // R6

  AST_TASK_STEP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.go && ctl.kind == ACC_TASK) |-> (stepCnt < STEP_W'(TASK_STEPS)))
    else $error("task step out of range"); // R2

  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (pollLimitQ != '0) |-> (pollCnt < pollLimitQ))
    else $error("poll counter passed limit"); // R9

endmodule

// File: rtl/ata_seq_ctrl.sv
module ata_seq_ctrl
  import ata_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        isWriteQ,
  input  logic        accDone,
  input  logic [7:0]  statusByte,
  input  logic        taskLast,
  input  logic        wordLast,
  input  logic        pollExpired,
  output ctlStrobes_t ctl,
  output logic        busy,
  output logic        done,
  output logic        error
);

  typedef enum logic [3:0] {
    S_IDLE, S_TASK_GO, S_TASK_WAIT, S_POLLA_GO, S_POLLA_WAIT,
    S_XFER_GO, S_XFER_WAIT, S_POLLB_GO, S_POLLB_WAIT
  } sState_t;

  sState_t state, nextState;
  logic    setDone, setErr;

  always_comb begin
    ctl       = '0;
    ctl.kind  = ACC_TASK;
    nextState = state;
    setDone   = 1'b0;
    setErr    = 1'b0;
    case (state)
      S_IDLE: begin
        if (start) begin
          ctl.loadParams = 1'b1;
          nextState      = S_TASK_GO;
        end
      end
      S_TASK_GO: begin
        ctl.go    = 1'b1;
        ctl.kind  = ACC_TASK;
        nextState = S_TASK_WAIT;
      end
      S_TASK_WAIT: begin
        if (accDone) begin
          if (taskLast) begin
            ctl.clrPoll = 1'b1;
            nextState   = S_POLLA_GO;
          end else begin
            ctl.incStep = 1'b1;
            nextState   = S_TASK_GO;
          end
        end
      end
      S_POLLA_GO, S_POLLB_GO: begin
        ctl.go    = 1'b1;
        ctl.rd    = 1'b1;
        ctl.kind  = ACC_STATUS;
        nextState = (state == S_POLLA_GO) ? S_POLLA_WAIT : S_POLLB_WAIT;
      end
      S_POLLA_WAIT: begin
        ctl.kind = ACC_STATUS;
        if (accDone) begin
          if (statusByte[0]) begin
            setErr    = 1'b1;
            nextState = S_IDLE;
          end else if (statusByte == ST_DRQ) begin
            ctl.clrStep = 1'b1;
            nextState   = S_XFER_GO;
          end else if (pollExpired) begin
            setErr    = 1'b1;
            nextState = S_IDLE;
          end else begin
            ctl.incPoll = 1'b1;
            nextState   = S_POLLA_GO;
          end
        end
      end
      S_XFER_GO: begin
        ctl.go    = 1'b1;
        ctl.rd    = !isWriteQ;
        ctl.kind  = ACC_DATA;
        nextState = S_XFER_WAIT;
      end
      S_XFER_WAIT: begin
        ctl.kind = ACC_DATA;
        if (accDone) begin
          ctl.bufWrite = !isWriteQ;
          if (wordLast) begin
            ctl.clrPoll = 1'b1;
            nextState   = S_POLLB_GO;
          end else begin
            ctl.incStep = 1'b1;
            nextState   = S_XFER_GO;
          end
        end
      end
      S_POLLB_WAIT: begin
        ctl.kind = ACC_STATUS;
        if (accDone) begin
          if (statusByte[0]) begin
            setErr    = 1'b1;
            nextState = S_IDLE;
          end else if (statusByte == ST_READY) begin
            setDone   = 1'b1;
            nextState = S_IDLE;
          end else if (pollExpired) begin
            setErr    = 1'b1;
            nextState = S_IDLE;
          end else begin
            ctl.incPoll = 1'b1;
            nextState   = S_POLLB_GO;
          end
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      state <= nextState;
      done  <= setDone;
      error <= setErr;
    end
  end

  assign busy = (state != S_IDLE);

  AST_DONE_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error)) else $error("done and error together"); // R8

  AST_END_IS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (done || error) |-> !busy) else $error("busy at end of sequence"); // R7

  AST_END_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    (done || error) |-> $past(accDone)) else $error("end not tied to a completed read"); // R9

  AST_START_ACCEPTED: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy) else $error("start not accepted"); // R11

  AST_NO_RELOAD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ctl.loadParams) else $error("parameters reloaded mid-sequence"); // R11

endmodule

// File: rtl/ata_sector_seq.sv
module ata_sector_seq
  import ata_seq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int STROBE_W = 8,
  parameter int POLL_W   = 16,
  parameter int WORDS    = 256,
  localparam int STEP_W  = (WORDS > 8) ? $clog2(WORDS) : 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                isWrite,
  input  logic [15:0]         cylinder,
  input  logic [3:0]          head,
  input  logic                driveSel,
  input  logic [7:0]          sectorNum,
  input  logic [STROBE_W-1:0] strobeLen,
  input  logic [POLL_W-1:0]   pollLimit,
  output logic [2:0]          busAddr,
  output logic                ce1N,
  output logic                iordN,
  output logic                iowrN,
  output logic [DATA_W-1:0]   dataOut,
  output logic                dataOutEn,
  input  logic [DATA_W-1:0]   dataIn,
  output logic [STEP_W-1:0]   bufAddr,
  input  logic [DATA_W-1:0]   bufRdData,
  output logic                bufWrEn,
  output logic [DATA_W-1:0]   bufWrData,
  output logic                busy,
  output logic                done,
  output logic                error
);

  ctlStrobes_t ctl;
  logic        accDone;
  logic [7:0]  statusByte;
  logic        taskLast;
  logic        wordLast;
  logic        pollExpired;
  logic        isWriteQ;

  ata_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .isWriteQ   (isWriteQ),
    .accDone    (accDone),
    .statusByte (statusByte),
    .taskLast   (taskLast),
    .wordLast   (wordLast),
    .pollExpired(pollExpired),
    .ctl        (ctl),
    .busy       (busy),
    .done       (done),
    .error      (error)
  );

  ata_seq_datapath #(
    .DATA_W  (DATA_W),
    .STROBE_W(STROBE_W),
    .POLL_W  (POLL_W),
    .WORDS   (WORDS),
    .STEP_W  (STEP_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .isWrite    (isWrite),
    .cylinder   (cylinder),
    .head       (head),
    .driveSel   (driveSel),
    .sectorNum  (sectorNum),
    .strobeLen  (strobeLen),
    .pollLimit  (pollLimit),
    .dataIn     (dataIn),
    .bufRdData  (bufRdData),
    .busAddr    (busAddr),
    .ce1N       (ce1N),
    .iordN      (iordN),
    .iowrN      (iowrN),
    .dataOut    (dataOut),
    .dataOutEn  (dataOutEn),
    .bufAddr    (bufAddr),
    .bufWrEn    (bufWrEn),
    .bufWrData  (bufWrData),
    .accDone    (accDone),
    .statusByte (statusByte),
    .taskLast   (taskLast),
    .wordLast   (wordLast),
    .pollExpired(pollExpired),
    .isWriteQ   (isWriteQ)
  );

endmodule

// File: tb/ata_sector_seq_tb.sv
module ata_sector_seq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        isWrite = 1'b0;
  logic [15:0] cylinder = '0;
  logic [3:0]  head = '0;
  logic        driveSel = 1'b0;
  logic [7:0]  sectorNum = '0;
  logic [7:0]  strobeLen = 8'd1;
  logic [15:0] pollLimit = 16'd100;
  logic [2:0]  busAddr;
  logic        ce1N, iordN, iowrN, dataOutEn;
  logic [15:0] dataOut;
  logic [15:0] dataIn = '0;
  logic [7:0]  bufAddr;
  logic [15:0] bufRdData;
  logic        bufWrEn;
  logic [15:0] bufWrData;
  logic        busy, done, error;

  always #5 clk = ~clk;

  ata_sector_seq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .isWrite(isWrite), .cylinder(cylinder),
    .head(head), .driveSel(driveSel), .sectorNum(sectorNum), .strobeLen(strobeLen),
    .pollLimit(pollLimit), .busAddr(busAddr), .ce1N(ce1N), .iordN(iordN), .iowrN(iowrN),
    .dataOut(dataOut), .dataOutEn(dataOutEn), .dataIn(dataIn), .bufAddr(bufAddr),
    .bufRdData(bufRdData), .bufWrEn(bufWrEn), .bufWrData(bufWrData),
    .busy(busy), .done(done), .error(error)
  );

  int total = 0;
  int bad = 0;

  logic [15:0] bufMem [256];
  logic [15:0] capBuf [256];
  assign bufRdData = bufMem[bufAddr];

  // device model state
  int          devB1, devB2, devMode, devCnt, devIdx;
  bit          devPhaseB;
  logic [15:0] dataBase;
  // bus log
  int          logN;
  int          logAddr [1024];
  bit          logRd   [1024];
  logic [15:0] logData [1024];
  // strobe monitor
  int          expLen, widthErr, setupErr, holdErr, strbCnt;
  bit          prevLow, prevRd, prevSel;
  logic [2:0]  prevAddr, strbAddr;
  logic [7:0]  stat;

  function automatic logic [15:0] patWord(input logic [15:0] base, input int i);
    return base ^ (16'(i) * 16'h0105);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!iordN || !iowrN) begin
      if (!prevLow) begin
        if (!prevSel || prevAddr != busAddr) setupErr++;
        strbCnt  = 1;
        strbAddr = busAddr;
      end else begin
        strbCnt++;
      end
      prevRd = !iordN;
    end else if (prevLow) begin
      if (ce1N || busAddr != strbAddr) holdErr++;
      if (strbCnt != expLen) widthErr++;
      if (logN < 1024) begin
        logAddr[logN] = int'(strbAddr);
        logRd[logN]   = prevRd;
        logData[logN] = prevRd ? dataIn : dataOut;
        logN++;
      end
      if (strbAddr == 3'd7 && prevRd) devCnt++;
      if (strbAddr == 3'd0) begin
        devIdx++;
        if (!devPhaseB) begin devPhaseB = 1; devCnt = 0; end
      end
    end
    if (bufWrEn) capBuf[bufAddr] = bufWrData;
    prevLow  = !iordN || !iowrN;
    prevSel  = !ce1N;
    prevAddr = busAddr;
    if (!devPhaseB)
      stat = (devMode == 3 || devCnt < devB1) ? 8'h80 : (devMode == 1 ? 8'h51 : 8'h58);
    else
      stat = (devCnt < devB2) ? 8'h80 : (devMode == 2 ? 8'h51 : 8'h50);
    if (busAddr == 3'd7)      dataIn <= {8'h00, stat};
    else if (busAddr == 3'd0) dataIn <= patWord(dataBase, devIdx);
    else                      dataIn <= 16'h0000;
  end

  // mode: 0 normal, 1 error in first poll, 2 error in final poll, 3 first poll never ready
  task automatic runTxn(input bit wr, input logic [15:0] cyl, input logic [3:0] hd,
                        input logic [7:0] sn, input bit drv, input logic [7:0] sl,
                        input logic [15:0] pl, input int b1, input int b2,
                        input int mode, input bit poke);
    int doneCnt, errCnt, k, nA, nB, expN, mism, firstBad;
    bit fin, busyAtEnd;
    logic [7:0]  tData [6];
    int          tAddr [6];
    logic [15:0] w;
    tAddr = '{4, 5, 6, 3, 2, 7};
    tData = '{cyl[7:0], cyl[15:8], {3'b101, drv, hd}, sn, 8'h01, wr ? 8'h30 : 8'h20};
    dataBase = 16'($urandom);
    for (int i = 0; i < 256; i++) begin bufMem[i] = 16'($urandom); capBuf[i] = 16'hxxxx; end
    devB1 = b1; devB2 = b2; devMode = mode; devCnt = 0; devIdx = 0; devPhaseB = 0;
    logN = 0; widthErr = 0; setupErr = 0; holdErr = 0;
    expLen = (sl == 0) ? 1 : int'(sl);
    @(negedge clk);
    isWrite = wr; cylinder = cyl; head = hd; sectorNum = sn; driveSel = drv;
    strobeLen = sl; pollLimit = pl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    doneCnt = 0; errCnt = 0; fin = 0; busyAtEnd = 1;
    for (int c = 0; c < 40000 && !fin; c++) begin
      @(negedge clk);
      if (done) doneCnt++;
      if (error) errCnt++;
      if (done || error) begin fin = 1; busyAtEnd = busy; end
      if (poke && c == 40) begin start = 1'b1; cylinder = ~cyl; isWrite = !wr; sectorNum = ~sn; end
      else if (poke && c == 41) begin start = 1'b0; cylinder = cyl; isWrite = wr; sectorNum = sn; end
    end
    repeat (6) begin
      @(negedge clk);
      if (done) doneCnt++;
      if (error) errCnt++;
    end

    // task-file programming
    mism = 0; firstBad = -1;
    for (int i = 0; i < 6; i++)
      if (logAddr[i] != tAddr[i] || logRd[i] ||
          (i != 2 && i != 5 && logData[i] != {8'h00, tData[i]})) begin
        mism++; if (firstBad < 0) firstBad = i;
      end
    chk(mism == 0 && logN >= 6, "R2", "task write order/value", firstBad, -1);
    chk(logData[2] == {8'h00, tData[2]}, "R3", "drive/head byte", logData[2], {8'h00, tData[2]});
    chk(logData[5] == {8'h00, tData[5]}, "R4", "command byte", logData[5], {8'h00, tData[5]});

    // first polling phase
    nA = (mode == 3) ? ((pl == 0) ? 1 : int'(pl)) : b1 + 1;
    mism = 0; firstBad = -1;
    for (int i = 0; i < nA; i++) begin
      k = 6 + i;
      w = (i < nA - 1 || mode == 3) ? 16'h0080 : (mode == 1 ? 16'h0051 : 16'h0058);
      if (logAddr[k] != 7 || !logRd[k] || logData[k] != w) begin
        mism++; if (firstBad < 0) firstBad = k;
      end
    end
    chk(mism == 0, "R5", "status poll before burst", firstBad, -1);

    if (mode == 1 || mode == 3) begin
      expN = 6 + nA;
      chk(errCnt == 1 && doneCnt == 0, mode == 1 ? "R8" : "R9", "error pulse count",
          errCnt * 16 + doneCnt, 16);
      chk(logN == expN, mode == 1 ? "R8" : "R9", "accesses after failure", logN, expN);
    end else begin
      mism = 0; firstBad = -1;
      for (int i = 0; i < 256; i++) begin
        k = 6 + nA + i;
        w = wr ? bufMem[i] : patWord(dataBase, i);
        if (logAddr[k] != 0 || logRd[k] != !wr || logData[k] != w ||
            (!wr && capBuf[i] !== w)) begin
          mism++; if (firstBad < 0) firstBad = i;
        end
      end
      chk(mism == 0, "R6", wr ? "write burst words" : "read burst words", firstBad, -1);
      nB = b2 + 1;
      mism = 0; firstBad = -1;
      for (int i = 0; i < nB; i++) begin
        k = 6 + nA + 256 + i;
        w = (i < nB - 1) ? 16'h0080 : (mode == 2 ? 16'h0051 : 16'h0050);
        if (logAddr[k] != 7 || !logRd[k] || logData[k] != w) begin
          mism++; if (firstBad < 0) firstBad = k;
        end
      end
      chk(mism == 0, "R7", "final status poll", firstBad, -1);
      expN = 6 + nA + 256 + nB;
      if (mode == 2) begin
        chk(errCnt == 1 && doneCnt == 0, "R8", "error in final poll", errCnt * 16 + doneCnt, 16);
        chk(logN == expN, "R8", "accesses after failure", logN, expN);
      end else begin
        chk(doneCnt == 1 && errCnt == 0 && !busyAtEnd, "R7", "done pulse / busy low",
            doneCnt * 16 + errCnt, 16);
        chk(logN == expN, poke ? "R11" : "R7", "total access count", logN, expN);
      end
    end
    chk(widthErr == 0, "R10", "strobe width errors", widthErr, 0);
    chk(setupErr == 0 && holdErr == 0, "R10", "setup/hold errors", setupErr * 1000 + holdErr, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    prevLow = 0; prevSel = 0; prevAddr = '0; strbAddr = '0; strbCnt = 0; prevRd = 0;
    devB1 = 0; devB2 = 0; devMode = 0; devCnt = 0; devIdx = 0; devPhaseB = 0;
    logN = 0; expLen = 1; widthErr = 0; setupErr = 0; holdErr = 0; dataBase = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(iordN && iowrN && ce1N && !busy && !done && !error, "R1", "reset state",
        {iordN, iowrN, ce1N, busy, done, error}, 6'b111000);

    // directed corners
    runTxn(0, 16'h1234, 4'h5, 8'h07, 1'b0, 8'd1, 16'd100, 0, 0, 0, 0);
    runTxn(1, 16'hBEEF, 4'hA, 8'h3C, 1'b1, 8'd3, 16'd100, 2, 3, 0, 0);
    runTxn(0, 16'h00FF, 4'h0, 8'h01, 1'b1, 8'd0, 16'd100, 1, 1, 0, 0);
    runTxn(1, 16'h4321, 4'hF, 8'hFF, 1'b0, 8'd2, 16'd100, 1, 0, 1, 0);
    runTxn(0, 16'h0A0B, 4'h3, 8'h10, 1'b0, 8'd1, 16'd100, 0, 2, 2, 0);
    runTxn(0, 16'h5555, 4'h6, 8'h22, 1'b1, 8'd1, 16'd4, 0, 0, 3, 0);
    runTxn(1, 16'h7777, 4'h2, 8'h33, 1'b0, 8'd1, 16'd0, 0, 0, 3, 0);
    runTxn(0, 16'hC0DE, 4'h9, 8'h44, 1'b1, 8'd2, 16'd100, 1, 1, 0, 1);

    // random transfers
    for (int n = 0; n < 6; n++)
      runTxn(1'($urandom), 16'($urandom), 4'($urandom), 8'($urandom), 1'($urandom),
             8'($urandom % 5), 16'd100, int'($urandom % 4), int'($urandom % 4), 0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule